// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Recognizer

This block watches a one-bit serial stream, taking one sample per rising clock edge, and raises a flag each time the four most recent samples read 1, 1, 0, 1 from oldest to newest. Overlaps count. A trailing 1 that closes one match can also open the next one, and a long run of 1s ahead of the 0 still leads to a match. So the stream 1101101 gives two hits, and 1111101 gives one hit.

The block drives two flags from two separate state machines. The early flag comes from a four-state machine. It is combinational on the live input and rises in the same cycle that the closing 1 is present. The late flag comes from a five-state machine with an extra "hit" state. It is fully registered and rises for the one cycle after the closing 1 has been clocked in.

A compile-time parameter selects the state code for both machines: dense counting order, reflected Gray order, or one flop per state. The choice changes area and logic depth only. Behaviour at the ports is the same for all three.

Top module: `pat1101_recognizer`

## Requirements
- R1: A synchronous active-high reset returns both machines to the idle state, with no partial pattern remembered. Neither flag is high in the first cycle after reset is released. A pattern that was partly received before the reset is not completed by bits that arrive after it.
- R2: `hit_mealy` is high in a cycle if and only if `serial_in` is 1 in that cycle and the three samples clocked in since reset just before it were 1, 1, 0 (oldest first).
- R3: Overlapping occurrences are all flagged. After a match, the closing 1 counts as the first 1 of the next pattern, so the stream 1101101 raises `hit_mealy` on its 4th and 7th bits.
- R4: Any run of two or more 1s followed by 0 and then 1 is a match. The stream 1111101 raises `hit_mealy` only on its 7th bit.
- R5: `hit_mealy` is never high in two consecutive cycles.
- R6: `hit_moore` in every cycle equals the value `hit_mealy` had in the previous cycle, for any input stream.
- R7: `hit_moore` depends only on registered state. Changing `serial_in` within a cycle does not change it.
- R8: The `ENCODING` parameter selects counting order (idle, 1, 11, 110 as 00, 01, 10, 11), Gray order (00, 01, 11, 10), or one-hot (0001, 0010, 0100, 1000). Both flags behave the same under every setting. A state code that no legal state uses goes back to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; `serial_in` is sampled once per edge |
| rst | input | 1 | Synchronous active-high reset to the idle state |
| serial_in | input | 1 | Serial data bit |
| hit_mealy | output | 1 | High while the bit now on `serial_in` completes 1101 |
| hit_moore | output | 1 | High for the cycle after a completing bit was clocked in |

## Verification
A corrupted state register shows up at the ports within a few bits. If the machine wrongly forgets the 11 prefix, a hit is lost when the 1 arrives after the 0. If it wrongly enters the 110 state, a spurious hit appears on the very next 1. If the two machines drift apart, `hit_moore` stops matching a one-cycle-delayed `hit_mealy` at the first divergent hit. The stimulus therefore uses long random streams biased toward 1s, so that many overlapping matches and long runs of 1s occur. It also checks directly the cases of reset in the middle of a pattern and of input changes within a cycle. All three encodings run side by side against the same expected values.

// File: rtl/seqrec_pkg.sv
`timescale 1ns/1ps
package seqrec_pkg;

    // Selectable state code style shared by both machines
    typedef enum logic [1:0] {
        ENC_COUNT  = 2'd0,
        ENC_GRAY   = 2'd1,
        ENC_ONEHOT = 2'd2
    } enc_style_e;

    // Abstract progress through the pattern; ST_HIT exists only in the registered-output machine
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ONE   = 3'd1,
        ST_ONES  = 3'd2,
        ST_ONZ   = 3'd3,
        ST_HIT   = 3'd4
    } phase_e;

    localparam int MAX_STATES = 5;
    localparam int CODE_W     = MAX_STATES;

    // Flop count needed for a given code style and state count
    function automatic int state_bits(enc_style_e style, int n_states);
        if (style == ENC_ONEHOT)
            return n_states;
        return $clog2(n_states);
    endfunction

    // Code word of an abstract state, zero-extended to CODE_W bits
    function automatic logic [CODE_W-1:0] phase_code(phase_e p, enc_style_e style);
        logic [2:0] idx;
        idx = 3'(p);
        case (style)
            ENC_COUNT: return CODE_W'(idx);
            ENC_GRAY:  return CODE_W'(idx ^ (idx >> 1));
            default:   return CODE_W'(1) << idx;
        endcase
    endfunction

    // Abstract next state; with_hit selects the five-state variant
    function automatic phase_e phase_step(phase_e cur, logic bit_in, logic with_hit);
        phase_e nxt;
        case (cur)
            ST_IDLE: nxt = bit_in ? ST_ONE  : ST_IDLE;
            ST_ONE:  nxt = bit_in ? ST_ONES : ST_IDLE;
            ST_ONES: nxt = bit_in ? ST_ONES : ST_ONZ;
            ST_ONZ:  nxt = bit_in ? (with_hit ? ST_HIT : ST_ONE) : ST_IDLE;
            ST_HIT:  nxt = bit_in ? ST_ONES : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rec_dense_core.sv
`timescale 1ns/1ps
// Binary-coded state register (counting or Gray order), next state through the abstract table
module rec_dense_core
    import seqrec_pkg::*;
#(
    parameter enc_style_e ENC  = ENC_COUNT,
    parameter int         N_ST = 4,
    parameter int         SW   = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   din,
    output phase_e phase
);
    localparam bit WITH_HIT = (N_ST == 5);
    localparam logic [SW-1:0] IDLE_CODE = SW'(phase_code(ST_IDLE, ENC));

    logic [SW-1:0] st_q;
    logic [SW-1:0] st_d;
    phase_e        cur;
    logic          legal;

    // Decode the register into an abstract state; unused codes are flagged illegal
    always_comb begin
        cur   = ST_IDLE;
        legal = 1'b0;
        for (int i = 0; i < N_ST; i++) begin
            if (st_q == SW'(phase_code(phase_e'(3'(i)), ENC))) begin
                cur   = phase_e'(3'(i));
                legal = 1'b1;
            end
        end
    end

    always_comb begin
        if (legal)
            st_d = SW'(phase_code(phase_step(cur, din, WITH_HIT), ENC));
        else
            st_d = IDLE_CODE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= IDLE_CODE;
        else
            st_q <= st_d;
    end

    assign phase = cur;

endmodule

// File: rtl/rec_onehot_core.sv
`timescale 1ns/1ps
// One flop per state; each next-state bit reads only the flops of its predecessors
module rec_onehot_core
    import seqrec_pkg::*;
#(
    parameter int N_ST = 4,
    parameter int SW   = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   din,
    output phase_e phase
);
    localparam bit WITH_HIT = (N_ST == 5);

    logic [SW-1:0]         hot_q;
    logic [SW-1:0]         hot_d;
    logic [MAX_STATES-1:0] q5;
    logic [MAX_STATES-1:0] d5;
    logic                  legal;
    logic                  s_idle, s_one, s_ones, s_onz, s_hit;

    assign q5     = MAX_STATES'(hot_q);
    assign s_idle = q5[0];
    assign s_one  = q5[1];
    assign s_ones = q5[2];
    assign s_onz  = q5[3];
    assign s_hit  = q5[4];
    assign legal  = $onehot(hot_q);

    always_comb begin
        d5    = '0;
        d5[0] = ~din & (s_idle | s_one | s_onz | s_hit);
        d5[1] =  din & (s_idle | (~WITH_HIT & s_onz));
        d5[2] =  din & (s_one | s_ones | s_hit);
        d5[3] = ~din & s_ones;
        d5[4] =  din & WITH_HIT & s_onz;
        hot_d = legal ? d5[SW-1:0] : SW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            hot_q <= SW'(1);
        else
            hot_q <= hot_d;
    end

    always_comb begin
        phase = ST_IDLE;
        if (legal) begin
            for (int i = 0; i < N_ST; i++) begin
                if (q5[i])
                    phase = phase_e'(3'(i));
            end
        end
    end

endmodule

// File: rtl/rec_machine.sv
`timescale 1ns/1ps
// One recognizer machine: picks a core by code style and forms its flag
module rec_machine
    import seqrec_pkg::*;
#(
    parameter enc_style_e ENC      = ENC_COUNT,
    parameter bit         WITH_HIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic flag
);
    localparam int N_ST = WITH_HIT ? 5 : 4;
    localparam int SW   = state_bits(ENC, N_ST);

    phase_e phase;

    generate
        if (ENC == ENC_ONEHOT) begin : g_hot
            rec_onehot_core #(.N_ST(N_ST), .SW(SW)) u_core (
                .clk   (clk),
                .rst   (rst),
                .din   (din),
                .phase (phase)
            );
        end else begin : g_dense
            rec_dense_core #(.ENC(ENC), .N_ST(N_ST), .SW(SW)) u_core (
                .clk   (clk),
                .rst   (rst),
                .din   (din),
                .phase (phase)
            );
        end
    endgenerate

    generate
        if (WITH_HIT) begin : g_reg_flag
            assign flag = (phase == ST_HIT);
        end else begin : g_comb_flag
            assign flag = (phase == ST_ONZ) && din;
        end
    endgenerate

endmodule

// File: rtl/pat1101_recognizer.sv
`timescale 1ns/1ps
// Top: early (combinational) and late (registered) recognizers side by side
module pat1101_recognizer
    import seqrec_pkg::*;
#(
    parameter enc_style_e ENCODING = ENC_GRAY
) (
    input  logic clk,
    input  logic rst,
    input  logic serial_in,
    output logic hit_mealy,
    output logic hit_moore
);

    rec_machine #(.ENC(ENCODING), .WITH_HIT(1'b0)) u_early (
        .clk  (clk),
        .rst  (rst),
        .din  (serial_in),
        .flag (hit_mealy)
    );

    rec_machine #(.ENC(ENCODING), .WITH_HIT(1'b1)) u_late (
        .clk  (clk),
        .rst  (rst),
        .din  (serial_in),
        .flag (hit_moore)
    );

endmodule

// File: rtl/pat1101_recognizer_chk.sv
`timescale 1ns/1ps
module pat1101_recognizer_chk (
    input logic clk,
    input logic rst,
    input logic serial_in,
    input logic hit_mealy,
    input logic hit_moore
);
    // Independent history of samples since reset
    logic [2:0] hist;
    logic [1:0] seen;
    logic       armed = 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist  <= '0;
            seen  <= '0;
            armed <= 1'b1;
        end else begin
            hist <= {hist[1:0], serial_in};
            if (seen != 2'd3)
                seen <= seen + 2'd1;
        end
    end

    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst || !armed)
        $past(rst) |-> (!hit_mealy && !hit_moore));

    assert_flag_needs_one_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        hit_mealy |-> serial_in);

    assert_window_match_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        hit_mealy == ((seen == 2'd3) && (hist == 3'b110) && serial_in));

    assert_no_back_to_back_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        hit_mealy |=> !hit_mealy);

    assert_late_is_delayed_R6: assert property (@(posedge clk) disable iff (rst || !armed || seen == 2'd0)
        hit_moore == $past(hit_mealy));

endmodule

bind pat1101_recognizer pat1101_recognizer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .serial_in (serial_in),
    .hit_mealy (hit_mealy),
    .hit_moore (hit_moore)
);

// File: tb/pat1101_recognizer_tb.sv
`timescale 1ns/1ps
module pat1101_recognizer_tb;
    import seqrec_pkg::*;

    localparam real CLK_HALF = 2.0;
    localparam int  WATCHDOG = 200000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din = 1'b0;
    logic m_cnt, n_cnt, m_gry, n_gry, m_hot, n_hot;

    int checks = 0;
    int errors = 0;

    // Reference model state
    bit [2:0] ref_hist = '0;
    int       ref_seen = 0;
    bit       ref_late = 1'b0;
    bit       ref_early;
    int       hits_seen = 0;

    always #(CLK_HALF) clk = ~clk;

    pat1101_recognizer #(.ENCODING(ENC_COUNT)) u_dut (
        .clk(clk), .rst(rst), .serial_in(din), .hit_mealy(m_cnt), .hit_moore(n_cnt));
    pat1101_recognizer #(.ENCODING(ENC_GRAY)) u_dut_gray (
        .clk(clk), .rst(rst), .serial_in(din), .hit_mealy(m_gry), .hit_moore(n_gry));
    pat1101_recognizer #(.ENCODING(ENC_ONEHOT)) u_dut_hot (
        .clk(clk), .rst(rst), .serial_in(din), .hit_mealy(m_hot), .hit_moore(n_hot));

    function automatic bit expect_early(bit [2:0] h, int seen, bit b);
        return (seen >= 3) && (h == 3'b110) && b;
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string req, input bit e_early, input bit e_late);
        check(req, "count early", m_cnt, e_early);
        check(req, "count late",  n_cnt, e_late);
        check(req, "gray early",  m_gry, e_early);
        check(req, "gray late",   n_gry, e_late);
        check(req, "hot early",   m_hot, e_early);
        check(req, "hot late",    n_hot, e_late);
    endtask

    // One serial bit; wiggle toggles the input inside the cycle first (R7)
    task automatic step(input bit b, input string req, input bit wiggle = 1'b0);
        @(negedge clk);
        if (wiggle) begin
            din = ~b;
            #0.5;
            check("R7", "count late wiggle", n_cnt, ref_late);
            check("R7", "gray late wiggle",  n_gry, ref_late);
            check("R7", "hot late wiggle",   n_hot, ref_late);
        end
        din = b;
        #1;
        ref_early = expect_early(ref_hist, ref_seen, b);
        if (ref_early) hits_seen++;
        check_all(req, ref_early, ref_late);
        @(posedge clk);
        ref_late = ref_early;
        ref_hist = {ref_hist[1:0], b};
        ref_seen++;
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        din = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        din = 1'b1;
        ref_hist = '0;
        ref_seen = 0;
        ref_late = 1'b0;
        #1;
        check_all(req, 1'b0, 1'b0);
        din = 1'b0;
    endtask

    task automatic feed(input bit [15:0] pat, input int len, input string req);
        for (int i = len - 1; i >= 0; i--)
            step(pat[i], req);
    endtask

    initial begin
        #(2.0 * CLK_HALF * WATCHDOG);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int h0;
        void'($urandom(32'h1d0b_5eed));

        // R1: reset state with input held high
        do_reset("R1");

        // R2: plain 1101 after reset, hit on the 4th bit
        h0 = hits_seen;
        feed(16'b1101, 4, "R2");
        check("R2", "hit count", 1'(hits_seen - h0 == 1), 1'b1);

        // R3: overlap, 101 after a match completes a second match
        h0 = hits_seen;
        feed(16'b101, 3, "R3");
        check("R3", "overlap hit count", 1'(hits_seen - h0 == 1), 1'b1);

        // R4: long run of ones then 01
        step(0, "R4"); step(0, "R4");
        h0 = hits_seen;
        feed(16'b1111101, 7, "R4");
        check("R4", "run hit count", 1'(hits_seen - h0 == 1), 1'b1);

        // R5: back-to-back candidate, 1101 then 1 must not flag twice
        feed(16'b0011011, 7, "R5");

        // R7: late flag is high after a match; wiggle input during that cycle
        feed(16'b00110, 5, "R6");
        step(1, "R6");
        step(1, "R7", 1'b1);
        step(0, "R7", 1'b1);

        // R1: a pattern cut by reset does not complete
        feed(16'b0110, 4, "R1");
        do_reset("R1");
        step(1, "R1");
        step(1, "R1");

        // R8 / R6: biased random stream over all three encodings
        do_reset("R1");
        for (int n = 0; n < 4000; n++) begin
            bit b;
            b = (($urandom % 4) != 0);
            step(b, "R8", (n % 97) == 0);
        end
        check("R8", "random stream produced hits", 1'(hits_seen > 20), 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule